// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block keeps a circular list of receive descriptors in a small on-block descriptor memory and steps through it as packets arrive. Every descriptor is one 48-bit word. The upper 16 bits are a status word, and the lower 32 bits point at the packet buffer. The status word carries four control flags and one result bit. The ownership ("empty") flag says whether the engine may fill the buffer. The wrap flag marks the last entry of the ring. The interrupt-request flag asks for an event when the descriptor closes. The continuous flag keeps the descriptor owned by the engine after it closes. The result bit records an aborted packet.

When the receive path signals a new packet, the controller reads the current descriptor. If the engine owns it, the controller presents the buffer pointer and waits for a completion strobe that carries an error flag. It then writes the closed status back and moves to the next entry. If the wrap flag was set, the next entry is the programmed ring base. If the host still owns the descriptor, the packet is dropped and an overrun pulse is raised.

Closing a descriptor that requests an interrupt pushes an exception entry, as long as the global receive-interrupt enable is on. Each pushed entry also counts down an interrupt counter that the host loads. When that counter reaches zero, a sticky global interrupt bit is set. The host shares the single-port descriptor memory with the engine and always wins the port.

Top module: `rxr_ring_ctrl`

## Requirements
- R1: After reset the current index, ring base, interrupt counter and global interrupt bit are all 0. The outputs buf_valid, busy_ovr, exc_push, irq and host_rvalid are all low.
- R2: A host write with host_req=1 and host_wr=1 stores host_wdata at host_idx. The status word sits in bits 47:32 and the pointer in bits 31:0. A host read with host_req=1 and host_wr=0 sets host_rvalid in the next cycle, and host_rdata then holds the stored word.
- R3: A pkt_start pulse in idle fetches the descriptor at cur_idx. If status bit 0 (empty) is 1, buf_valid rises with buf_ptr equal to the pointer field and buf_idx equal to cur_idx, and it stays high until pkt_done.
- R4: If the fetched status bit 0 is 0, busy_ovr pulses for one cycle and buf_valid stays low. Neither cur_idx nor the stored descriptor changes.
- R5: On close, the written-back status keeps bit 2 (wrap), bit 3 (interrupt request) and bit 7 (continuous). Bit 1 takes the pkt_err value and bit 0 takes the value of bit 7. All other status bits are written as 0, and the pointer is unchanged.
- R6: After a close, cur_idx becomes the ring base if the closed status had bit 2 set. Otherwise it becomes cur_idx+1, and index DEPTH-1 steps to 0. The index changes at no other time except a base load.
- R7: A base_ld pulse loads base_val into both the ring base and cur_idx.
- R8: Closing a descriptor whose status bit 3 is 1 while rx_int_en is 1 gives a one-cycle exc_push pulse, with exc_idx naming the closed descriptor. No other event gives a pulse.
- R9: Each exc_push event decrements int_cnt if it is above 0. The step from 1 to 0 sets gint_status and gives a one-cycle irq pulse. At 0 the counter stays at 0 and irq does not fire.
- R10: gint_status stays set until a gint_clr pulse. A cnt_load pulse writes cnt_val into int_cnt.
- R11: While host_req is high the engine makes no memory access. A pending fetch or write-back waits, and buf_valid does not rise during the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host memory access request |
| host_wr | input | 1 | Host access is a write |
| host_idx | input | IDX_W | Host descriptor index |
| host_wdata | input | 48 | Host write word |
| host_rdata | output | 48 | Host read word |
| host_rvalid | output | 1 | host_rdata valid |
| base_ld | input | 1 | Load ring base and current index |
| base_val | input | IDX_W | New ring base |
| rx_int_en | input | 1 | Global receive-interrupt enable |
| cnt_load | input | 1 | Load interrupt counter |
| cnt_val | input | CNT_W | Counter load value |
| gint_clr | input | 1 | Clear global interrupt bit |
| gint_status | output | 1 | Sticky global interrupt bit |
| irq | output | 1 | Interrupt pulse on counter reaching zero |
| pkt_start | input | 1 | New packet arriving |
| pkt_done | input | 1 | Packet complete |
| pkt_err | input | 1 | Packet aborted with error |
| buf_valid | output | 1 | Buffer pointer presented |
| buf_ptr | output | 32 | Buffer pointer |
| buf_idx | output | IDX_W | Index of open descriptor |
| busy_ovr | output | 1 | Packet dropped, descriptor host-owned |
| cur_idx | output | IDX_W | Current ring index |
| exc_push | output | 1 | Exception entry pushed |
| exc_idx | output | IDX_W | Descriptor index of pushed entry |
| int_cnt | output | CNT_W | Interrupt counter value |

## Verification
The bench builds rings at different bases with the wrap flag placed at random. It checks that the ring returns to the base and not to entry 0; a design that ignored the base would walk off into stale entries. Host-owned descriptors are mixed in to show that an overrun leaves both the index and the stored word untouched. Continuous-mode entries are read back to confirm that they come back still marked empty and are reused on the next pass. The interrupt counter is driven down to zero and then past it: an early irq, a repeated irq, or a wrap of the counter to its maximum would each show up as wrong counts. A host read is held across a pending fetch to catch an engine that takes the memory port from the host.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int DESC_W = 48;

  // status bit positions inside bits 47:32 of a descriptor
  localparam int ST_EMPTY = 0;
  localparam int ST_ERR   = 1;
  localparam int ST_WRAP  = 2;
  localparam int ST_IRQ   = 3;
  localparam int ST_CONT  = 7;

  typedef struct packed {
    logic [15:0] status;
    logic [31:0] ptr;
  } rxr_desc_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FETCH,
    S_CHECK,
    S_OPEN,
    S_CLOSE
  } rxr_state_e;

  // status written back when a descriptor is closed
  function automatic logic [15:0] close_status(input logic [15:0] st, input logic err);
    logic [15:0] r;
    r           = '0;
    r[ST_WRAP]  = st[ST_WRAP];
    r[ST_IRQ]   = st[ST_IRQ];
    r[ST_CONT]  = st[ST_CONT];
    r[ST_EMPTY] = st[ST_CONT];
    r[ST_ERR]   = err;
    return r;
  endfunction

endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem #(
  parameter int DEPTH = 16,
  parameter int DW    = 48,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) store[addr] <= wdata;
      rdata <= store[addr];
    end
  end

endmodule

// File: rtl/rxr_port_arb.sv
module rxr_port_arb #(
  parameter int AW = 4,
  parameter int DW = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_wr,
  input  logic [AW-1:0] host_idx,
  input  logic [DW-1:0] host_wdata,
  output logic          host_rvalid,
  output logic          host_busy,
  input  logic          eng_en,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_addr,
  input  logic [DW-1:0] eng_wdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  assign host_busy = host_req;

  always_comb begin
    if (host_req) begin
      mem_en    = 1'b1;
      mem_we    = host_wr;
      mem_addr  = host_idx;
      mem_wdata = host_wdata;
    end else begin
      mem_en    = eng_en;
      mem_we    = eng_we;
      mem_addr  = eng_addr;
      mem_wdata = eng_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) host_rvalid <= 1'b0;
    else        host_rvalid <= host_req && !host_wr;
  end

endmodule

// File: rtl/rxr_ring_fsm.sv
module rxr_ring_fsm
  import rxr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              pkt_done,
  input  logic              pkt_err,
  input  logic              host_busy,
  input  logic              base_ld,
  input  logic [AW-1:0]     base_val,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              eng_en,
  output logic              eng_we,
  output logic [AW-1:0]     eng_addr,
  output logic [DESC_W-1:0] eng_wdata,
  output logic              buf_valid,
  output logic [31:0]       buf_ptr,
  output logic              busy_ovr,
  output logic [AW-1:0]     cur_idx,
  output logic              close_evt,
  output logic              close_irq
);

  rxr_state_e state;
  rxr_desc_t  desc_q;
  rxr_desc_t  fetched;
  logic [AW-1:0] base_q;
  logic          err_q;

  function automatic logic [AW-1:0] step_idx(input logic [AW-1:0] idx, input logic wrap,
                                             input logic [AW-1:0] base);
    if (wrap)        return base;
    if (idx == LAST) return '0;
    return idx + AW'(1);
  endfunction

  assign fetched   = rxr_desc_t'(mem_rdata);
  assign buf_valid = (state == S_OPEN);
  assign buf_ptr   = desc_q.ptr;
  assign close_evt = (state == S_CLOSE) && !host_busy;
  assign close_irq = close_evt && desc_q.status[ST_IRQ];

  always_comb begin
    eng_en    = 1'b0;
    eng_we    = 1'b0;
    eng_addr  = cur_idx;
    eng_wdata = {close_status(desc_q.status, err_q), desc_q.ptr};
    if (state == S_FETCH) eng_en = !host_busy;
    if (state == S_CLOSE) begin
      eng_en = !host_busy;
      eng_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      desc_q   <= '0;
      err_q    <= 1'b0;
      busy_ovr <= 1'b0;
      cur_idx  <= '0;
      base_q   <= '0;
    end else begin
      busy_ovr <= 1'b0;
      unique case (state)
        S_IDLE:  if (pkt_start) state <= S_FETCH;
        S_FETCH: if (!host_busy) state <= S_CHECK;
        S_CHECK: begin
          if (fetched.status[ST_EMPTY]) begin
            desc_q <= fetched;
            state  <= S_OPEN;
          end else begin
            busy_ovr <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_OPEN: begin
          if (pkt_done) begin
            err_q <= pkt_err;
            state <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          if (!host_busy) begin
            cur_idx <= step_idx(cur_idx, desc_q.status[ST_WRAP], base_q);
            state   <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (base_ld) begin
        base_q  <= base_val;
        cur_idx <= base_val;
      end
    end
  end

endmodule

// File: rtl/rxr_int_coal.sv
module rxr_int_coal #(
  parameter int AW    = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [AW-1:0]    evt_idx,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             gint_clr,
  output logic             exc_push,
  output logic [AW-1:0]    exc_idx,
  output logic [CNT_W-1:0] int_cnt,
  output logic             gint_status,
  output logic             irq
);

  logic fire;

  function automatic logic [CNT_W-1:0] dec_sat(input logic [CNT_W-1:0] c);
    return (c == '0) ? c : c - CNT_W'(1);
  endfunction

  assign fire = evt && !cnt_load && (int_cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_push    <= 1'b0;
      exc_idx     <= '0;
      int_cnt     <= '0;
      gint_status <= 1'b0;
      irq         <= 1'b0;
    end else begin
      exc_push <= evt;
      if (evt) exc_idx <= evt_idx;
      if (cnt_load)  int_cnt <= cnt_val;
      else if (evt)  int_cnt <= dec_sat(int_cnt);
      irq <= fire;
      if (fire)          gint_status <= 1'b1;
      else if (gint_clr) gint_status <= 1'b0;
    end
  end

endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl
  import rxr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [IDX_W-1:0]  host_idx,
  input  logic [DESC_W-1:0] host_wdata,
  output logic [DESC_W-1:0] host_rdata,
  output logic              host_rvalid,
  input  logic              base_ld,
  input  logic [IDX_W-1:0]  base_val,
  input  logic              rx_int_en,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_val,
  input  logic              gint_clr,
  output logic              gint_status,
  output logic              irq,
  input  logic              pkt_start,
  input  logic              pkt_done,
  input  logic              pkt_err,
  output logic              buf_valid,
  output logic [31:0]       buf_ptr,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              busy_ovr,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              exc_push,
  output logic [IDX_W-1:0]  exc_idx,
  output logic [CNT_W-1:0]  int_cnt
);

  logic              host_busy;
  logic              eng_en, eng_we;
  logic [IDX_W-1:0]  eng_addr;
  logic [DESC_W-1:0] eng_wdata;
  logic              mem_en, mem_we;
  logic [IDX_W-1:0]  mem_addr;
  logic [DESC_W-1:0] mem_wdata, mem_rdata;
  logic              close_evt, close_irq, push_evt;

  assign host_rdata = mem_rdata;
  assign buf_idx    = cur_idx;
  assign push_evt   = close_irq && rx_int_en;

  rxr_desc_mem #(.DEPTH(DEPTH), .DW(DESC_W)) u_mem (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wdata), .rdata(mem_rdata)
  );

  rxr_port_arb #(.AW(IDX_W), .DW(DESC_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_wr(host_wr), .host_idx(host_idx),
    .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_busy(host_busy),
    .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  rxr_ring_fsm #(.DEPTH(DEPTH)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .pkt_start(pkt_start), .pkt_done(pkt_done), .pkt_err(pkt_err),
    .host_busy(host_busy), .base_ld(base_ld), .base_val(base_val),
    .mem_rdata(mem_rdata),
    .eng_en(eng_en), .eng_we(eng_we), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .buf_valid(buf_valid), .buf_ptr(buf_ptr), .busy_ovr(busy_ovr),
    .cur_idx(cur_idx), .close_evt(close_evt), .close_irq(close_irq)
  );

  rxr_int_coal #(.AW(IDX_W), .CNT_W(CNT_W)) u_coal (
    .clk(clk), .rst_n(rst_n),
    .evt(push_evt), .evt_idx(cur_idx),
    .cnt_load(cnt_load), .cnt_val(cnt_val), .gint_clr(gint_clr),
    .exc_push(exc_push), .exc_idx(exc_idx), .int_cnt(int_cnt),
    .gint_status(gint_status), .irq(irq)
  );

endmodule

// File: rtl/rxr_ring_chk.sv
module rxr_ring_chk #(
  parameter int IDX_W = 4,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             host_req,
  input logic             eng_en,
  input logic             close_evt,
  input logic             base_ld,
  input logic [IDX_W-1:0] cur_idx,
  input logic [CNT_W-1:0] int_cnt,
  input logic             cnt_load,
  input logic             irq,
  input logic             gint_status,
  input logic             gint_clr,
  input logic             exc_push,
  input logic             rx_int_en,
  input logic             buf_valid,
  input logic             busy_ovr
);

  a_r11_host_first: assert property (@(posedge clk) disable iff (!rst_n)
    host_req |-> !eng_en);

  a_r4_ovr_no_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_valid, busy_ovr}));

  a_r6_index_moves_on_close: assert property (@(posedge clk) disable iff (!rst_n)
    (!close_evt && !base_ld) |=> $stable(cur_idx));

  a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (int_cnt == '0 && !cnt_load) |=> int_cnt == '0);

  a_r9_irq_sets_gint: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> gint_status);

  a_r10_gint_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (gint_status && !gint_clr) |=> gint_status);

  a_r8_push_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    exc_push |-> $past(rx_int_en));

endmodule

bind rxr_ring_ctrl rxr_ring_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_req(host_req), .eng_en(eng_en),
  .close_evt(close_evt), .base_ld(base_ld), .cur_idx(cur_idx),
  .int_cnt(int_cnt), .cnt_load(cnt_load), .irq(irq),
  .gint_status(gint_status), .gint_clr(gint_clr), .exc_push(exc_push),
  .rx_int_en(rx_int_en), .buf_valid(buf_valid), .busy_ovr(busy_ovr)
);

// File: tb/rxr_ring_ctrl_tb.sv
module rxr_ring_ctrl_tb;

  localparam int DEPTH = 16;
  localparam int IW    = 4;
  localparam int CW    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 0, host_wr = 0;
  logic [IW-1:0] host_idx = '0;
  logic [47:0] host_wdata = '0, host_rdata;
  logic host_rvalid;
  logic base_ld = 0;
  logic [IW-1:0] base_val = '0;
  logic rx_int_en = 0, cnt_load = 0, gint_clr = 0;
  logic [CW-1:0] cnt_val = '0;
  logic gint_status, irq;
  logic pkt_start = 0, pkt_done = 0, pkt_err = 0;
  logic buf_valid, busy_ovr, exc_push;
  logic [31:0] buf_ptr;
  logic [IW-1:0] buf_idx, cur_idx, exc_idx;
  logic [CW-1:0] int_cnt;

  always #5 clk = ~clk;

  rxr_ring_ctrl #(.DEPTH(DEPTH), .CNT_W(CW)) u_dut (.*);

  int checks = 0, bad = 0;
  int seen_exc = 0, seen_irq = 0, exp_exc = 0, exp_irq = 0;
  logic [IW-1:0] last_exc_idx = '0;

  logic [47:0] mdesc [DEPTH];
  logic [IW-1:0] mbase = '0, midx = '0, exp_exc_idx = '0;
  logic [CW-1:0] mcnt = '0;
  logic mgint = 0;

  always @(posedge clk) begin
    if (rst_n && exc_push) begin seen_exc++; last_exc_idx = exc_idx; end
    if (rst_n && irq) seen_irq++;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_close(input logic [15:0] st, input logic err);
    logic [15:0] r = 16'h0;
    r = st & 16'h008C;      // wrap, irq-request, continuous survive
    r[0] = st[7];
    r[1] = err;
    return r;
  endfunction

  function automatic logic [IW-1:0] exp_next(input logic [IW-1:0] i, input logic w);
    if (w) return mbase;
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  task automatic host_write(input logic [IW-1:0] i, input logic [47:0] d);
    @(negedge clk); host_req = 1; host_wr = 1; host_idx = i; host_wdata = d;
    @(negedge clk); host_req = 0; host_wr = 0;
    mdesc[i] = d;
  endtask

  task automatic host_read(input logic [IW-1:0] i, output logic [47:0] d, output logic v);
    @(negedge clk); host_req = 1; host_wr = 0; host_idx = i;
    @(negedge clk); host_req = 0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic verify_desc(input logic [IW-1:0] i, input string tag);
    logic [47:0] d; logic v;
    host_read(i, d, v);
    check(v && d === mdesc[i], tag, d, mdesc[i]);
  endtask

  task automatic load_base(input logic [IW-1:0] b);
    @(negedge clk); base_ld = 1; base_val = b;
    @(negedge clk); base_ld = 0;
    mbase = b; midx = b;
    check(cur_idx == b, "R7 base load", cur_idx, b);
  endtask

  task automatic load_cnt(input logic [CW-1:0] c);
    @(negedge clk); cnt_load = 1; cnt_val = c;
    @(negedge clk); cnt_load = 0;
    mcnt = c;
    check(int_cnt == c, "R10 counter load", int_cnt, c);
  endtask

  task automatic run_packet(input logic err, input int hold);
    logic [47:0] d = mdesc[midx];
    bit got_buf = 0, got_ovr = 0;
    @(negedge clk); pkt_start = 1;
    @(negedge clk); pkt_start = 0;
    if (hold > 0) begin
      host_req = 1; host_wr = 0; host_idx = midx;
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        check(!buf_valid, "R11 engine waits for host", buf_valid, 0);
      end
      host_req = 0;
    end
    for (int k = 0; k < 10 && !got_buf && !got_ovr; k++) begin
      if (buf_valid) got_buf = 1;
      else if (busy_ovr) got_ovr = 1;
      else @(negedge clk);
    end
    if (d[32]) begin
      check(got_buf, "R3 buffer opened", got_buf, 1);
      check(buf_ptr == d[31:0] && buf_idx == midx, "R3 pointer and index",
            {buf_idx, buf_ptr}, {midx, d[31:0]});
      pkt_err = err; pkt_done = 1;
      @(negedge clk); pkt_done = 0; pkt_err = 0;
      repeat (4) @(negedge clk);
      mdesc[midx] = {exp_close(d[47:32], err), d[31:0]};
      if (d[35] && rx_int_en) begin
        exp_exc++; exp_exc_idx = midx;
        if (mcnt != 0) begin
          mcnt--;
          if (mcnt == 0) begin exp_irq++; mgint = 1; end
        end
      end
      midx = exp_next(midx, d[34]);
    end else begin
      check(got_ovr && !got_buf, "R4 overrun on host-owned", got_ovr, 1);
      repeat (2) @(negedge clk);
    end
    check(cur_idx == midx, "R6 ring index", cur_idx, midx);
    check(seen_exc == exp_exc, "R8 exception count", seen_exc, exp_exc);
    if (exp_exc > 0)
      check(last_exc_idx == exp_exc_idx, "R8 exception index", last_exc_idx, exp_exc_idx);
    check(seen_irq == exp_irq && int_cnt == mcnt && gint_status == mgint,
          "R9 coalescing", {seen_irq[15:0], int_cnt, 7'd0, gint_status},
          {exp_irq[15:0], mcnt, 7'd0, mgint});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [47:0] d; logic v;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(cur_idx == 0 && int_cnt == 0 && !gint_status, "R1 reset regs",
          {cur_idx, int_cnt, gint_status}, 0);
    check(!buf_valid && !busy_ovr && !exc_push && !irq && !host_rvalid, "R1 reset outputs",
          {buf_valid, busy_ovr, exc_push, irq, host_rvalid}, 0);

    // R2 host write/read
    for (int i = 0; i < DEPTH; i++) host_write(IW'(i), {16'h0000, 32'h1000_0000 + i});
    host_write(4'd5, 48'h008D_CAFE_F00D);
    host_read(4'd5, d, v);
    check(v && d == 48'h008D_CAFE_F00D, "R2 host readback", d, 48'h008D_CAFE_F00D);

    // directed ring 2..5, wrap at 5, continuous at 4, host-owned at 3 first
    load_base(4'd2);
    host_write(4'd2, {16'h0009, 32'hA000_0002});   // empty, irq
    host_write(4'd3, {16'h0000, 32'hA000_0003});   // host owned
    host_write(4'd4, {16'h0081, 32'hA000_0004});   // empty, continuous
    host_write(4'd5, {16'h000D, 32'hA000_0005});   // empty, irq, wrap
    @(negedge clk); rx_int_en = 1;
    load_cnt(8'd2);
    run_packet(1'b0, 3);                           // R11 hold, R3
    verify_desc(4'd2, "R5 closed good");
    run_packet(1'b0, 0);                           // R4 overrun at 3
    verify_desc(4'd3, "R4 descriptor untouched");
    host_write(4'd3, {16'h0001, 32'hA000_0003});   // hand back
    run_packet(1'b1, 0);                           // 3 with error
    verify_desc(4'd3, "R5 error bit");
    run_packet(1'b0, 0);                           // 4 continuous
    verify_desc(4'd4, "R5 continuous keeps empty");
    run_packet(1'b0, 0);                           // 5 wrap, irq fires
    check(cur_idx == 4'd2, "R6 wrap to base", cur_idx, 4'd2);
    run_packet(1'b0, 0);                           // 2 now host-owned: overrun
    host_write(4'd2, {16'h0009, 32'hA000_0002});
    run_packet(1'b0, 0);                           // counter at 0: no new irq
    check(int_cnt == 0, "R9 counter held at zero", int_cnt, 0);
    @(negedge clk); gint_clr = 1;
    @(negedge clk); gint_clr = 0; mgint = 0;
    check(!gint_status, "R10 gint cleared", gint_status, 0);

    // random rings
    for (int r = 0; r < 6; r++) begin
      logic [IW-1:0] b = IW'($urandom_range(0, DEPTH - 1));
      int len = $urandom_range(1, 6);
      load_base(b);
      for (int i = 0; i < len; i++) begin
        logic [15:0] st = 16'h0;
        st[0] = ($urandom_range(0, 4) != 0);
        st[3] = $urandom_range(0, 1);
        st[7] = ($urandom_range(0, 3) == 0);
        st[2] = (i == len - 1);
        host_write(IW'(b + i), {st, $urandom()});
      end
      load_cnt(CW'($urandom_range(1, 4)));
      @(negedge clk); rx_int_en = ($urandom_range(0, 3) != 0);
      for (int p = 0; p < 10; p++) begin
        logic [IW-1:0] was = midx;
        run_packet(1'($urandom_range(0, 1)), $urandom_range(0, 2));
        verify_desc(was, "R5 random closed word");
        if (!mdesc[was][32] && $urandom_range(0, 1))
          host_write(was, {mdesc[was][47:33], 1'b1, mdesc[was][31:0]});
      end
      if (gint_status) begin
        @(negedge clk); gint_clr = 1;
        @(negedge clk); gint_clr = 0; mgint = 0;
      end
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule